// File: doc/BRIEF.md
# DDR3 Command Decoder and Bank Tracker

This block sits on the device side of a DDR3-style command bus. At every rising clock edge it samples the chip select, the RAS, CAS and WE strobes, the clock enable, the bank address and the address bus. It turns them into one registered command code. The possible codes are activate, read, write, single-bank precharge, all-bank precharge, refresh, mode register set and no-operation.

Along with each command the block reports the target bank and the raw address. For reads and writes it also reports the auto-precharge and burst-chop qualifiers. It keeps an open/closed flag and the latched row for every bank. It flags accesses that do not match the bank state.

Clock enable drives a small power tracker. When clock enable is sampled low, the tracker classifies the low period as self-refresh, precharge power-down or active power-down, depending on the command and on whether any bank is open. While clock enable stays low, command decoding is suppressed. When clock enable returns high, the tracker signals the exit for one cycle.

Top module: `ddr3_cmd_tracker`

## Requirements
- R1: After reset the command output is no-operation (code 0), every bank is closed, the error flag is low, the power state is ACTIVE (code 0) and the exit strobe is low.
- R2: An edge where cs_n is sampled high yields no-operation and leaves every bank state and latched row unchanged, whatever the RAS/CAS/WE levels.
- R3: With cs_n low and cke high, the {ras_n,cas_n,we_n} levels decode as follows. 011 gives activate (code 1), 101 gives read (2), 100 gives write (3) and 001 gives refresh (6). 000 gives mode register set (7) and 111 gives no-operation (0). The result appears on cmd in the cycle after the sampling edge.
- R4: An activate to a closed bank opens that bank and latches addr[ROW_W-1:0] into that bank's slice of open_rows, bits [bank*ROW_W +: ROW_W].
- R5: On a read or write, addr[10] high sets cmd_ap and closes the accessed bank after the command. addr[10] low clears cmd_ap and leaves the bank open.
- R6: On a read or write, addr[12] low sets cmd_chop and addr[12] high clears it. cmd_chop is low for all other commands.
- R7: A precharge (010) with addr[10] low reports code 4 and closes only the bank named by ba. With addr[10] high it reports code 5 and closes every bank.
- R8: err is raised with a read or write to a closed bank, or with an activate to an open bank. An activate to an open bank leaves that bank's latched row unchanged.
- R9: A mode register set reports code 7, puts the register select (ba) on cmd_bank and leaves every bank state unchanged.
- R10: On the first edge where cke is sampled low, pwr takes one of three values. It becomes SELF_REFRESH (3) if that edge carries a refresh command. Otherwise it becomes ACT_PD (2) if any bank is open, and PRE_PD (1) if all banks are idle. While cke stays low, pwr holds, cmd is no-operation and bank state is unchanged.
- R11: On the first edge where cke is sampled high after being low, pwr returns to ACTIVE and pd_exit pulses high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write enable strobe |
| ba | input | BANK_W (3) | Bank address / mode register select |
| addr | input | ADDR_W (16) | Row, column or opcode; bit 10 and bit 12 are qualifiers |
| cmd | output | 3 | Decoded command code |
| cmd_bank | output | BANK_W (3) | Bank of the reported command |
| cmd_addr | output | ADDR_W (16) | Address captured with the command |
| cmd_ap | output | 1 | Auto-precharge requested |
| cmd_chop | output | 1 | Chopped burst requested |
| err | output | 1 | Command illegal for the current bank state |
| bank_open | output | NUM_BANKS (8) | Per-bank open flag |
| open_rows | output | NUM_BANKS*ROW_W (128) | Latched row of each bank |
| pwr | output | 2 | Power state |
| pd_exit | output | 1 | One-cycle power-down exit strobe |

## Verification
The bench uses the default parameters: eight banks, a 16-bit address bus and 16-bit rows. Eight banks let the tests open the lowest and highest bank indices together and confirm that a single-bank precharge leaves the others alone. The full 16-bit row lets rows with the top bit set be latched and read back. The 16-bit address also covers both qualifier bits, 10 and 12, so every auto-precharge and burst-chop combination and all three power-down outcomes can be driven.

// File: rtl/ddr3_trk_pkg.sv
package ddr3_trk_pkg;
   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_PREA = 3'd5,
      CMD_REF  = 3'd6,
      CMD_MRS  = 3'd7
   } cmd_t;

   typedef enum logic [1:0] {
      PWR_ACTIVE = 2'd0,
      PWR_PRE_PD = 2'd1,
      PWR_ACT_PD = 2'd2,
      PWR_SELF_REF = 2'd3
   } pwr_t;

   localparam int unsigned AP_BIT = 10;
   localparam int unsigned BC_BIT = 12;
endpackage

// File: rtl/ddr3_trk_decode.sv
module ddr3_trk_decode
   import ddr3_trk_pkg::*;
(
   input  logic enable,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic sel_all,
   output cmd_t cmd
);
   always_comb begin
      cmd = CMD_NOP;
      if (enable && !cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011: cmd = CMD_ACT;
            3'b101: cmd = CMD_RD;
            3'b100: cmd = CMD_WR;
            3'b010: cmd = sel_all ? CMD_PREA : CMD_PRE;
            3'b001: cmd = CMD_REF;
            3'b000: cmd = CMD_MRS;
            default: cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/ddr3_trk_bank.sv
module ddr3_trk_bank #(
   parameter int unsigned ROW_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic             close_en,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row     <= '0;
      end else if (open_en) begin
         is_open <= 1'b1;
         row     <= row_in;
      end else if (close_en) begin
         is_open <= 1'b0;
      end
   end
endmodule

// File: rtl/ddr3_trk_power.sv
module ddr3_trk_power
   import ddr3_trk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic refresh_req,
   input  logic any_open,
   output pwr_t pwr,
   output logic pd_exit
);
   logic cke_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cke_prev <= 1'b1;
         pwr      <= PWR_ACTIVE;
         pd_exit  <= 1'b0;
      end else begin
         cke_prev <= cke;
         pd_exit  <= cke && !cke_prev;
         if (cke) begin
            pwr <= PWR_ACTIVE;
         end else if (cke_prev) begin
            if (refresh_req)   pwr <= PWR_SELF_REF;
            else if (any_open) pwr <= PWR_ACT_PD;
            else               pwr <= PWR_PRE_PD;
         end
      end
   end
endmodule

// File: rtl/ddr3_cmd_tracker.sv
module ddr3_cmd_tracker
   import ddr3_trk_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned ROW_W     = 16,
   localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BANK_W-1:0]          ba,
   input  logic [ADDR_W-1:0]          addr,
   output logic [2:0]                 cmd,
   output logic [BANK_W-1:0]          cmd_bank,
   output logic [ADDR_W-1:0]          cmd_addr,
   output logic                       cmd_ap,
   output logic                       cmd_chop,
   output logic                       err,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] open_rows,
   output logic [1:0]                 pwr,
   output logic                       pd_exit
);
   initial begin
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS)
         $error("NUM_BANKS must be a power of two of at least 2");
      if (ADDR_W <= BC_BIT)
         $error("ADDR_W must cover the burst-chop bit");
      if (ROW_W > ADDR_W || ROW_W == 0)
         $error("ROW_W must lie within ADDR_W");
   end

   cmd_t dec;
   pwr_t pwr_s;
   logic is_access, target_open, illegal;
   logic refresh_req;

   ddr3_trk_decode u_dec (
      .enable (cke),
      .cs_n   (cs_n),
      .ras_n  (ras_n),
      .cas_n  (cas_n),
      .we_n   (we_n),
      .sel_all(addr[AP_BIT]),
      .cmd    (dec)
   );

   assign is_access   = (dec == CMD_RD) || (dec == CMD_WR);
   assign target_open = bank_open[ba];
   assign illegal     = (is_access && !target_open) || (dec == CMD_ACT && target_open);
   assign refresh_req = !cs_n && ({ras_n, cas_n, we_n} == 3'b001);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic hit;
      assign hit = (ba == BANK_W'(i));
      ddr3_trk_bank #(.ROW_W(ROW_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_en (hit && dec == CMD_ACT && !bank_open[i]),
         .close_en((dec == CMD_PREA) || (hit && dec == CMD_PRE) ||
                   (hit && is_access && addr[AP_BIT])),
         .row_in  (addr[ROW_W-1:0]),
         .is_open (bank_open[i]),
         .row     (open_rows[i*ROW_W +: ROW_W])
      );
   end

   ddr3_trk_power u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke        (cke),
      .refresh_req(refresh_req),
      .any_open   (|bank_open),
      .pwr        (pwr_s),
      .pd_exit    (pd_exit)
   );
   assign pwr = pwr_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd      <= CMD_NOP;
         cmd_bank <= '0;
         cmd_addr <= '0;
         cmd_ap   <= 1'b0;
         cmd_chop <= 1'b0;
         err      <= 1'b0;
      end else begin
         cmd      <= dec;
         cmd_bank <= ba;
         cmd_addr <= addr;
         cmd_ap   <= is_access && addr[AP_BIT];
         cmd_chop <= is_access && !addr[BC_BIT];
         err      <= illegal;
      end
   end
endmodule

// File: rtl/ddr3_cmd_tracker_chk.sv
module ddr3_cmd_tracker_chk #(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned BANK_W    = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic [2:0]           cmd,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_ap,
   input logic                 err,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [1:0]           pwr,
   input logic                 pd_exit
);
   // R2
   masked_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd == 3'd0));
   // R2
   masked_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> $stable(bank_open));
   // R4
   act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd1 && !err) |-> bank_open[cmd_bank]);
   // R5
   autopre_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd == 3'd2 || cmd == 3'd3) && cmd_ap) |-> !bank_open[cmd_bank]);
   // R7
   prea_all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd5) |-> (bank_open == '0));
   // R8
   err_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (cmd == 3'd1 || cmd == 3'd2 || cmd == 3'd3));
   // R10
   lowpower_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr != 2'd0) |-> (cmd == 3'd0));
   // R11
   exit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit |=> !pd_exit);
   // R11
   exit_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_exit |-> (pwr == 2'd0));
endmodule

bind ddr3_cmd_tracker ddr3_cmd_tracker_chk #(
   .NUM_BANKS(NUM_BANKS),
   .BANK_W   (BANK_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .cmd      (cmd),
   .cmd_bank (cmd_bank),
   .cmd_ap   (cmd_ap),
   .err      (err),
   .bank_open(bank_open),
   .pwr      (pwr),
   .pd_exit  (pd_exit)
);

// File: tb/ddr3_cmd_tracker_test.sv
module ddr3_cmd_tracker_test;
   localparam int NB = 8;
   localparam int AW = 16;
   localparam int RW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0] ba = '0;
   logic [AW-1:0] addr = '0;
   logic [2:0] cmd;
   logic [2:0] cmd_bank;
   logic [AW-1:0] cmd_addr;
   logic cmd_ap, cmd_chop, err, pd_exit;
   logic [NB-1:0] bank_open;
   logic [NB*RW-1:0] open_rows;
   logic [1:0] pwr;

   always #5 clk = ~clk;

   ddr3_cmd_tracker uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
      .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_ap(cmd_ap),
      .cmd_chop(cmd_chop), .err(err), .bank_open(bank_open),
      .open_rows(open_rows), .pwr(pwr), .pd_exit(pd_exit)
   );

   typedef struct {
      logic [2:0]       cmd;
      logic [2:0]       bank;
      logic             ap, chop, err, ex;
      logic [NB-1:0]    open;
      logic [NB*RW-1:0] rows;
      logic [1:0]       pwr;
      string            tag;
   } exp_t;

   exp_t q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   logic [NB-1:0]    m_open = '0;
   logic [NB*RW-1:0] m_rows = '0;
   logic [1:0]       m_pwr = 2'd0;
   logic             m_ckep = 1'b1;

   task automatic step(input string tag, input logic k, input logic c,
                       input logic [2:0] code, input logic [2:0] b,
                       input logic [AW-1:0] a);
      exp_t e;
      logic acc;
      @(negedge clk);
      cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
      e.cmd = 3'd0; e.bank = b; e.ap = 0; e.chop = 0; e.err = 0; e.ex = 0;
      e.tag = tag;
      if (!k) begin
         if (m_ckep) begin
            if (!c && code == 3'b001) m_pwr = 2'd3;
            else if (|m_open)         m_pwr = 2'd2;
            else                      m_pwr = 2'd1;
         end
      end else begin
         e.ex = !m_ckep;
         m_pwr = 2'd0;
         if (!c) begin
            case (code)
               3'b011: e.cmd = 3'd1;
               3'b101: e.cmd = 3'd2;
               3'b100: e.cmd = 3'd3;
               3'b010: e.cmd = a[10] ? 3'd5 : 3'd4;
               3'b001: e.cmd = 3'd6;
               3'b000: e.cmd = 3'd7;
               default: e.cmd = 3'd0;
            endcase
         end
         acc = (e.cmd == 3'd2 || e.cmd == 3'd3);
         e.ap   = acc && a[10];
         e.chop = acc && !a[12];
         e.err  = (acc && !m_open[b]) || (e.cmd == 3'd1 && m_open[b]);
         if (e.cmd == 3'd1 && !m_open[b]) begin
            m_open[b] = 1'b1;
            m_rows[b*RW +: RW] = a[RW-1:0];
         end
         if (e.cmd == 3'd4 || (acc && a[10])) m_open[b] = 1'b0;
         if (e.cmd == 3'd5) m_open = '0;
      end
      m_ckep = k;
      e.open = m_open; e.rows = m_rows; e.pwr = m_pwr;
      q.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #2;
         if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (cmd !== e.cmd || cmd_ap !== e.ap || cmd_chop !== e.chop ||
                err !== e.err || bank_open !== e.open || open_rows !== e.rows ||
                pwr !== e.pwr || pd_exit !== e.ex ||
                (e.cmd != 3'd0 && cmd_bank !== e.bank)) begin
               n_bad++;
               $display("FAIL %s: got cmd=%0d bank=%0d ap=%b chop=%b err=%b open=%b pwr=%0d exit=%b rows=%h exp cmd=%0d bank=%0d ap=%b chop=%b err=%b open=%b pwr=%0d exit=%b rows=%h",
                        e.tag, cmd, cmd_bank, cmd_ap, cmd_chop, err, bank_open, pwr, pd_exit, open_rows,
                        e.cmd, e.bank, e.ap, e.chop, e.err, e.open, e.pwr, e.ex, e.rows);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R1: reset state
      n_cmp++;
      if (cmd !== 3'd0 || bank_open !== '0 || err !== 1'b0 || pwr !== 2'd0 || pd_exit !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: got cmd=%0d open=%b err=%b pwr=%0d exp 0/0/0/0", cmd, bank_open, err, pwr);
      end
      rst_n = 1'b1;
      step("R1",  1, 0, 3'b111, 3'd0, 16'h0000);
      step("R3",  1, 0, 3'b001, 3'd0, 16'h0000);
      step("R9",  1, 0, 3'b000, 3'd2, 16'h0A5A);
      step("R4",  1, 0, 3'b011, 3'd3, 16'hBEEF);
      step("R4",  1, 0, 3'b011, 3'd7, 16'h8001);
      step("R8",  1, 0, 3'b011, 3'd3, 16'h1111);
      step("R6",  1, 0, 3'b101, 3'd3, 16'h0004);
      step("R6",  1, 0, 3'b100, 3'd7, 16'h1008);
      step("R5",  1, 0, 3'b101, 3'd3, 16'h0400);
      step("R8",  1, 0, 3'b100, 3'd3, 16'h0000);
      step("R2",  1, 1, 3'b011, 3'd0, 16'h0123);
      step("R2",  1, 1, 3'b010, 3'd7, 16'h0400);
      step("R4",  1, 0, 3'b011, 3'd0, 16'h0005);
      step("R7",  1, 0, 3'b010, 3'd0, 16'h0000);
      step("R4",  1, 0, 3'b011, 3'd1, 16'h7777);
      step("R7",  1, 0, 3'b010, 3'd5, 16'h0400);
      step("R10", 0, 0, 3'b111, 3'd0, 16'h0000);
      step("R10", 0, 0, 3'b011, 3'd4, 16'h4444);
      step("R11", 1, 0, 3'b111, 3'd0, 16'h0000);
      step("R4",  1, 0, 3'b011, 3'd2, 16'hC0DE);
      step("R10", 0, 0, 3'b111, 3'd0, 16'h0000);
      step("R10", 0, 1, 3'b111, 3'd0, 16'h0000);
      step("R11", 1, 0, 3'b100, 3'd2, 16'h0010);
      step("R10", 0, 0, 3'b001, 3'd0, 16'h0000);
      step("R10", 0, 0, 3'b010, 3'd2, 16'h0400);
      step("R11", 1, 0, 3'b111, 3'd0, 16'h0000);
      step("R6",  1, 0, 3'b101, 3'd2, 16'h1400);
      step("R3",  1, 0, 3'b111, 3'd0, 16'h0000);
      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule